// File: doc/BRIEF.md
# Sparse Parallel-Prefix Adder

A purely combinational binary adder for two WIDTH-bit operands (16 by default) with a carry input and a carry output. Each bit first forms its own generate and propagate pair from its two operand bits alone. The external carry input is merged into bit 0 as an extra generate term, so every carry the tree produces is the true carry at that position.

The carry network is sparse. Inside each SEG-bit group (4 bits by default), a radix-2 reduction tree compresses the bit pairs into one group pair. A radix-2 Kogge-Stone prefix then runs across the group pairs. It yields one carry per group: the carries into bits 4, 8 and 12, and the final carry out. Each of these carries, or the external carry input for the lowest group, drives a short ripple chain that forms that group's sum bits as propagate XOR incoming carry.

The block sits in a datapath wherever a wide add must settle in fewer logic levels than a full ripple chain. It has no clock and holds no state.

Top module: `sparse_prefix_adder`

## Requirements
- R1: sum_o equals (a_i + b_i + c_i) modulo 2^WIDTH for every combination of operands and carry input.
- R2: c_o equals bit WIDTH of the (WIDTH+1)-bit value a_i + b_i + c_i.
- R3: The carry input enters at bit 0. With both operands zero and c_i = 1, sum_o is 1 and c_o is 0.
- R4: At each group boundary k in {4, 8, 12}, the carry into bit k is sum_o[k] ^ a_i[k] ^ b_i[k]. It equals bit k of a_i[k-1:0] + b_i[k-1:0] + c_i, and it agrees with the carry leaving the ripple chain of the group below.
- R5: A carry crosses every group when all bits propagate. 0xFFFF + 0x0000 + 1 and 0x5555 + 0xAAAA + 1 each give sum 0x0000 with c_o = 1.
- R6: A generate in the top bit of a group, with no propagate below it in the next group, carries into that group's lowest bit. 0x8888 + 0x8888 + 0 gives sum 0x1110 with c_o = 1.
- R7: Sum bits below position k do not depend on operand bits at or above k. Changing only a_i[15:8] and b_i[15:8] leaves sum_o[7:0] unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| c_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum modulo 2^WIDTH |
| c_o | output | 1 | Carry out of the top bit |

## Verification
The in-line assertions are immediate checks on settled combinational values. They assume the inputs are two-state and are held stable long enough for the whole network to settle before they are evaluated. The bench changes the operands and c_i only on rising clock edges and reads the outputs at the following falling edge, so every comparison sees a settled adder. Every operand value is legal, so both the directed patterns and the random operand pairs stay within these assumptions without any filtering.

// File: rtl/spa_pkg.sv
package spa_pkg;
  localparam int unsigned WIDTH_DEF = 16;
  localparam int unsigned SEG_DEF   = 4;

  // radix-2 combining cell: (hi) o (lo)
  function automatic logic cell_g(input logic g_hi, input logic p_hi, input logic g_lo);
    return g_hi | (p_hi & g_lo);
  endfunction

  function automatic logic cell_p(input logic p_hi, input logic p_lo);
    return p_hi & p_lo;
  endfunction
endpackage

// File: rtl/spa_pg.sv
module spa_pg #(
  parameter int unsigned WIDTH = spa_pkg::WIDTH_DEF
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] g_o,
  output logic [WIDTH-1:0] p_o
);
  always_comb begin
    p_o = a_i ^ b_i;
    g_o = a_i & b_i;
    // carry input folded into bit 0
    g_o[0] = (a_i[0] & b_i[0]) | (p_o[0] & c_i);
  end

  always_comb begin
    assert_fold_R3: assert (g_o[0] == ((a_i[0] & b_i[0]) | ((a_i[0] | b_i[0]) & c_i)))
      else $error("bit0 fold mismatch");
  end
endmodule

// File: rtl/spa_sparse_tree.sv
module spa_sparse_tree #(
  parameter int unsigned WIDTH = spa_pkg::WIDTH_DEF,
  parameter int unsigned SEG   = spa_pkg::SEG_DEF
) (
  input  logic [WIDTH-1:0]     g_i,
  input  logic [WIDTH-1:0]     p_i,
  output logic [WIDTH/SEG-1:0] carry_o
);
  import spa_pkg::*;

  localparam int unsigned NSEG  = WIDTH / SEG;
  localparam int unsigned LK    = $clog2(NSEG);
  localparam int unsigned NODES = 2 * SEG - 1;

  // per-group heap: node k has children 2k+1 (low) and 2k+2 (high)
  logic [NODES-1:0] hg [NSEG];
  logic [NODES-1:0] hp [NSEG];
  logic [NSEG-1:0]  kg [LK+1];
  logic [NSEG-1:0]  kp [LK];
  logic             unused_p;

  always_comb begin
    for (int s = 0; s < NSEG; s++) begin
      hg[s] = '0;
      hp[s] = '0;
      for (int j = 0; j < SEG; j++) begin
        hg[s][SEG-1+j] = g_i[s*SEG+j];
        hp[s][SEG-1+j] = p_i[s*SEG+j];
      end
      for (int k = SEG - 2; k >= 0; k--) begin
        hg[s][k] = cell_g(hg[s][2*k+2], hp[s][2*k+2], hg[s][2*k+1]);
        hp[s][k] = cell_p(hp[s][2*k+2], hp[s][2*k+1]);
      end
    end

    for (int s = 0; s < NSEG; s++) begin
      kg[0][s] = hg[s][0];
      kp[0][s] = hp[s][0];
    end

    for (int l = 1; l <= LK; l++) begin
      for (int i = 0; i < NSEG; i++) begin
        if (i >= (1 << (l - 1))) begin
          kg[l][i] = cell_g(kg[l-1][i], kp[l-1][i], kg[l-1][i-(1<<(l-1))]);
          // the last level needs only the carry (gray cell)
          if (l < LK) kp[l][i] = cell_p(kp[l-1][i], kp[l-1][i-(1<<(l-1))]);
        end else begin
          kg[l][i] = kg[l-1][i];
          if (l < LK) kp[l][i] = kp[l-1][i];
        end
      end
    end
  end

  assign unused_p = ^kp[LK-1];
  assign carry_o  = kg[LK];
endmodule

// File: rtl/spa_ripple_seg.sv
module spa_ripple_seg #(
  parameter int unsigned SEG = spa_pkg::SEG_DEF
) (
  input  logic [SEG-1:0] g_i,
  input  logic [SEG-1:0] p_i,
  input  logic           c_i,
  output logic [SEG-1:0] s_o,
  output logic           c_o
);
  logic [SEG:0] c;

  always_comb begin
    c[0] = c_i;
    for (int k = 0; k < SEG; k++) begin
      s_o[k]   = p_i[k] ^ c[k];
      c[k+1]   = g_i[k] | (p_i[k] & c[k]);
    end
    c_o = c[SEG];
  end

  always_comb begin
    if (&p_i) begin
      assert_pass_R5: assert (c_o == c_i) else $error("segment failed to pass carry");
    end
  end
endmodule

// File: rtl/sparse_prefix_adder.sv
module sparse_prefix_adder #(
  parameter int unsigned WIDTH = spa_pkg::WIDTH_DEF,
  parameter int unsigned SEG   = spa_pkg::SEG_DEF
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_o
);
  localparam int unsigned NSEG = WIDTH / SEG;

  logic [WIDTH-1:0] g;
  logic [WIDTH-1:0] p;
  logic [NSEG-1:0]  tree_c;
  logic [NSEG-1:0]  rip_c;
  logic [NSEG-1:0]  seg_cin;

  spa_pg #(.WIDTH(WIDTH)) u_pg (
    .a_i(a_i), .b_i(b_i), .c_i(c_i), .g_o(g), .p_o(p)
  );

  spa_sparse_tree #(.WIDTH(WIDTH), .SEG(SEG)) u_tree (
    .g_i(g), .p_i(p), .carry_o(tree_c)
  );

  assign seg_cin = {tree_c[NSEG-2:0], c_i};

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    spa_ripple_seg #(.SEG(SEG)) u_seg (
      .g_i(g[s*SEG +: SEG]),
      .p_i(p[s*SEG +: SEG]),
      .c_i(seg_cin[s]),
      .s_o(sum_o[s*SEG +: SEG]),
      .c_o(rip_c[s])
    );
  end

  assign c_o = tree_c[NSEG-1];

  logic [WIDTH:0] ref_sum;
  always_comb begin
    ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, c_i};
    assert_sum_R1: assert (sum_o == ref_sum[WIDTH-1:0]) else $error("sum mismatch");
    assert_cout_R2: assert (c_o == ref_sum[WIDTH]) else $error("carry out mismatch");
    for (int s = 0; s < NSEG; s++) begin
      assert_seg_carry_R4: assert (rip_c[s] == tree_c[s]) else $error("tree/ripple carry mismatch");
    end
  end
endmodule

// File: tb/sparse_prefix_adder_bench.sv
module sparse_prefix_adder_bench;
  localparam int CLK_P = 10;
  localparam int W     = 16;

  logic         clk = 1'b0;
  logic [W-1:0] a_s = '0;
  logic [W-1:0] b_s = '0;
  logic         c_s = 1'b0;
  logic [W-1:0] sum_w;
  logic         co_w;
  int           checks = 0;
  int           errors = 0;

  always #(CLK_P/2) clk = ~clk;

  sparse_prefix_adder u_sparse_prefix_adder (
    .a_i(a_s), .b_i(b_s), .c_i(c_s), .sum_o(sum_w), .c_o(co_w)
  );

  function automatic logic [W:0] ref_add(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
  endfunction

  function automatic logic carry_into(input logic [W-1:0] a, input logic [W-1:0] b, input logic c, input int k);
    logic [W:0] la, lb;
    la = '0; lb = '0;
    for (int i = 0; i < k; i++) begin
      la[i] = a[i];
      lb[i] = b[i];
    end
    return ref_add(la[W-1:0], lb[W-1:0], c) >> k;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [W:0] got, input logic [W:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s a=%h b=%h cin=%b got=%h exp=%h", req, a_s, b_s, c_s, got, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    @(posedge clk);
    a_s = a; b_s = b; c_s = c;
    @(negedge clk);
  endtask

  task automatic check_all();
    logic [W:0] e;
    e = ref_add(a_s, b_s, c_s);
    chk(sum_w == e[W-1:0], "R1 sum", {1'b0, sum_w}, {1'b0, e[W-1:0]});
    chk(co_w == e[W], "R2 carry out", {{W{1'b0}}, co_w}, {{W{1'b0}}, e[W]});
    for (int k = 4; k < W; k += 4) begin
      logic obs, exp_c;
      obs   = sum_w[k] ^ a_s[k] ^ b_s[k];
      exp_c = carry_into(a_s, b_s, c_s, k);
      chk(obs == exp_c, "R4 boundary carry", {{W{1'b0}}, obs}, {{W{1'b0}}, exp_c});
    end
  endtask

  task automatic directed(input logic [W-1:0] a, input logic [W-1:0] b, input logic c,
                          input logic [W-1:0] es, input logic ec, input string req);
    apply(a, b, c);
    chk(sum_w == es && co_w == ec, req, {co_w, sum_w}, {ec, es});
    check_all();
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] lo_keep;
    void'($urandom(32'd20417));
    // R1 R2: quiescent zeros
    directed(16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, "R1 zeros");
    directed(16'h0000, 16'h0000, 1'b1, 16'h0001, 1'b0, "R3 cin only");
    directed(16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b1, "R5 full ripple");
    directed(16'h5555, 16'hAAAA, 1'b1, 16'h0000, 1'b1, "R5 alternating");
    directed(16'h5555, 16'hAAAA, 1'b0, 16'hFFFF, 1'b0, "R5 alternating no cin");
    directed(16'hFFFF, 16'hFFFF, 1'b1, 16'hFFFF, 1'b1, "R2 all ones");
    directed(16'hFFFF, 16'hFFFF, 1'b0, 16'hFFFE, 1'b1, "R2 all ones no cin");
    directed(16'h8888, 16'h8888, 1'b0, 16'h1110, 1'b1, "R6 group top generate");
    directed(16'h0008, 16'h0008, 1'b0, 16'h0010, 1'b0, "R6 single boundary");
    directed(16'h0FFF, 16'h0000, 1'b1, 16'h1000, 1'b0, "R4 carry to bit 12");

    // R7: upper operand bits do not touch lower sum bits
    for (int n = 0; n < 200; n++) begin
      logic [W-1:0] ra, rb;
      logic         rc;
      ra = W'($urandom()); rb = W'($urandom()); rc = 1'($urandom());
      apply(ra, rb, rc);
      lo_keep = sum_w;
      apply({ra[15:8] ^ 8'($urandom()), ra[7:0]}, {rb[15:8] ^ 8'($urandom()), rb[7:0]}, rc);
      chk(sum_w[7:0] == lo_keep[7:0], "R7 low sum isolation",
          {9'b0, sum_w[7:0]}, {9'b0, lo_keep[7:0]});
    end

    // R1 R2 R4: random operands with both carry inputs
    for (int n = 0; n < 10000; n++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom()); rb = W'($urandom());
      apply(ra, rb, 1'b0);
      check_all();
      apply(ra, rb, 1'b1);
      check_all();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule